// File: doc/BRIEF.md
# Ternary MIN-MAX Function Evaluator

This block computes one three-valued output from three three-valued inputs, using a sum-of-products form in which MIN takes the place of AND and MAX takes the place of OR. Each product term is built from three set-membership literals, one per input variable. A literal yields the top level 2 when its variable holds one of the values chosen by a programmable mask, and 0 otherwise. A term can also be weighted by a constant level of 1, which caps its contribution at 1.

The output is the MAX over all enabled terms. Masks, enables and caps are static configuration inputs, so one instance can be set up for any function in this form that fits in the available terms. An input carrying the unused code sets an error flag, and the output is forced to 0 while the flag is set. An optional output register adds one cycle of latency.

Top module: `tern_minmax_eval`

## Requirements
- R1: Ternary values are carried on 2 bits as 00 = 0, 01 = 1 and 10 = 2. The output `f_out` never carries the code 11.
- R2: A literal gives 2 when bit k of its 3-bit mask is set and its variable equals k. Otherwise it gives 0. Mask bits for term i sit at `[3*i +: 3]` of the mask bus for that variable.
- R3: An enabled term gives the MIN of its three literals and its constant level. The constant is 1 when the term's bit in `term_cap` is 1, and 2 when that bit is 0.
- R4: A term whose bit in `term_en` is 0 contributes 0. With all terms disabled, the output is 0 for every legal input.
- R5: For legal inputs, the output is the MAX over the values of all terms.
- R6: If any of `in_a`, `in_b` or `in_c` carries the code 11, `code_err` is 1 and `f_out` is 0. For legal inputs, `code_err` is 0.
- R7: With REG_OUT = 1, `f_out` and `code_err` reflect the inputs present at the previous rising clock edge. While `rst_n` is low, both outputs are 0.
- R8: Configure the terms as a^{0,1}·b^{0,1}, b^{0,1}·c^{1,2}, 1·a^{0} and 1·b^{0,1}. With this setup, inputs (a,b,c) = (1,2,0) give 0, (2,0,0) give 1 and (0,0,0) give 2.
- R9: An enabled, uncapped term whose three masks are all 111 gives 2 for every legal input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_a | input | 2 | Ternary variable a |
| in_b | input | 2 | Ternary variable b |
| in_c | input | 2 | Ternary variable c |
| term_en | input | NUM_TERMS | Per-term enable |
| term_cap | input | NUM_TERMS | Per-term constant: 1 selects level 1, 0 selects level 2 |
| mask_a | input | 3*NUM_TERMS | Membership masks applied to a, 3 bits per term |
| mask_b | input | 3*NUM_TERMS | Membership masks applied to b, 3 bits per term |
| mask_c | input | 3*NUM_TERMS | Membership masks applied to c, 3 bits per term |
| f_out | output | 2 | Ternary function value |
| code_err | output | 1 | Illegal input code seen |

## Verification
The bench builds the block with NUM_TERMS = 4 and REG_OUT = 1. Four terms are enough to hold the three-literal reference function with its two capped terms, and the register makes the one-cycle latency and the reset state visible.

Each term configuration is swept over all 27 legal input combinations. The configurations cover the reference function, partly disabled setups, all-full masks and all-off. The illegal code is then driven on each input in turn.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t LVL0 = 2'b00;
  localparam trit_t LVL1 = 2'b01;
  localparam trit_t LVL2 = 2'b10;

  function automatic logic trit_ok(trit_t x);
    return x != 2'b11;
  endfunction

  function automatic trit_t trit_min(trit_t x, trit_t y);
    return (x < y) ? x : y;
  endfunction

  function automatic trit_t trit_max(trit_t x, trit_t y);
    return (x > y) ? x : y;
  endfunction

  function automatic trit_t member_lvl(trit_t v, logic [2:0] set);
    logic hit;
    case (v)
      2'b00:   hit = set[0];
      2'b01:   hit = set[1];
      2'b10:   hit = set[2];
      default: hit = 1'b0;
    endcase
    return hit ? LVL2 : LVL0;
  endfunction
endpackage

// File: rtl/tern_literal.sv
module tern_literal
  import tern_pkg::*;
(
  input  logic [1:0] val,
  input  logic [2:0] set,
  output logic [1:0] lvl
);
  always_comb lvl = member_lvl(val, set);
endmodule

// File: rtl/tern_term.sv
module tern_term
  import tern_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic [1:0] c,
  input  logic [2:0] set_a,
  input  logic [2:0] set_b,
  input  logic [2:0] set_c,
  input  logic       en,
  input  logic       cap,
  output logic [1:0] val
);
  trit_t lit_a, lit_b, lit_c, weight;

  tern_literal u_la (.val(a), .set(set_a), .lvl(lit_a));
  tern_literal u_lb (.val(b), .set(set_b), .lvl(lit_b));
  tern_literal u_lc (.val(c), .set(set_c), .lvl(lit_c));

  always_comb begin
    weight = cap ? LVL1 : LVL2;
    if (en) val = trit_min(trit_min(lit_a, lit_b), trit_min(lit_c, weight));
    else    val = LVL0;
  end
endmodule

// File: rtl/tern_maxtree.sv
module tern_maxtree
  import tern_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] vals,
  output logic [1:0]     top
);
  always_comb begin
    top = LVL0;
    for (int i = 0; i < N; i++) top = trit_max(top, vals[2*i +: 2]);
  end
endmodule

// File: rtl/tern_minmax_eval.sv
module tern_minmax_eval
  import tern_pkg::*;
#(
  parameter int NUM_TERMS = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             in_a,
  input  logic [1:0]             in_b,
  input  logic [1:0]             in_c,
  input  logic [NUM_TERMS-1:0]   term_en,
  input  logic [NUM_TERMS-1:0]   term_cap,
  input  logic [3*NUM_TERMS-1:0] mask_a,
  input  logic [3*NUM_TERMS-1:0] mask_b,
  input  logic [3*NUM_TERMS-1:0] mask_c,
  output logic [1:0]             f_out,
  output logic                   code_err
);
  localparam int TW = 2 * NUM_TERMS;

  logic [TW-1:0] term_val;
  trit_t         f_comb;
  trit_t         f_next;
  logic          bad_code;

  for (genvar i = 0; i < NUM_TERMS; i++) begin : g_term
    tern_term u_term (
      .a(in_a), .b(in_b), .c(in_c),
      .set_a(mask_a[3*i +: 3]), .set_b(mask_b[3*i +: 3]), .set_c(mask_c[3*i +: 3]),
      .en(term_en[i]), .cap(term_cap[i]),
      .val(term_val[2*i +: 2])
    );
  end

  tern_maxtree #(.N(NUM_TERMS)) u_max (.vals(term_val), .top(f_comb));

  always_comb begin
    bad_code = !(trit_ok(in_a) && trit_ok(in_b) && trit_ok(in_c));
    f_next   = bad_code ? LVL0 : f_comb;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_out    <= LVL0;
        code_err <= 1'b0;
      end else begin
        f_out    <= f_next;
        code_err <= bad_code;
      end
    end
  end else begin : g_comb
    always_comb begin
      f_out    = f_next;
      code_err = bad_code;
    end
  end
endmodule

// File: rtl/tern_minmax_chk.sv
module tern_minmax_chk #(
  parameter int NUM_TERMS = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_TERMS-1:0]   term_en,
  input logic [NUM_TERMS-1:0]   term_cap,
  input logic [2*NUM_TERMS-1:0] term_val,
  input logic [1:0]             f_comb,
  input logic [1:0]             f_next,
  input logic [1:0]             f_out,
  input logic                   code_err
);
  assert_legal_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    f_out != 2'b11);

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> f_out == 2'b00);

  for (genvar i = 0; i < NUM_TERMS; i++) begin : g_t
    assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      term_cap[i] |-> term_val[2*i +: 2] != 2'b10);
    assert_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !term_en[i] |-> term_val[2*i +: 2] == 2'b00);
    assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      term_val[2*i +: 2] <= f_comb);
  end

  if (REG_OUT) begin : g_lat
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> f_out == $past(f_next));
  end
endmodule

bind tern_minmax_eval tern_minmax_chk #(.NUM_TERMS(NUM_TERMS), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .term_en(term_en), .term_cap(term_cap),
  .term_val(term_val), .f_comb(f_comb), .f_next(f_next),
  .f_out(f_out), .code_err(code_err)
);

// File: tb/tb_tern_minmax_eval.sv
module tb_tern_minmax_eval;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    in_a = 0, in_b = 0, in_c = 0;
  logic [NT-1:0] term_en = 0, term_cap = 0;
  logic [3*NT-1:0] mask_a = 0, mask_b = 0, mask_c = 0;
  logic [1:0]    f_out;
  logic          code_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tern_minmax_eval #(.NUM_TERMS(NT), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .term_en(term_en), .term_cap(term_cap),
    .mask_a(mask_a), .mask_b(mask_b), .mask_c(mask_c),
    .f_out(f_out), .code_err(code_err)
  );

  function automatic int imin(int x, int y); return x < y ? x : y; endfunction
  function automatic int imax(int x, int y); return x > y ? x : y; endfunction

  // behavioural model: set membership, weighting, then max over terms
  function automatic int model(int a, int b, int c);
    int best = 0;
    if (a > 2 || b > 2 || c > 2) return 0;
    for (int t = 0; t < NT; t++) begin
      int la, lb, lc, k, v;
      la = mask_a[3*t + a] ? 2 : 0;
      lb = mask_b[3*t + b] ? 2 : 0;
      lc = mask_c[3*t + c] ? 2 : 0;
      k  = term_cap[t] ? 1 : 2;
      v  = imin(imin(la, lb), imin(lc, k));
      if (!term_en[t]) v = 0;
      best = imax(best, v);
    end
    return best;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // inputs change at negedge, registered result read at the following negedge
  task automatic apply(int a, int b, int c, string req);
    int e; bit err;
    @(negedge clk);
    in_a = 2'(a); in_b = 2'(b); in_c = 2'(c);
    err = (a == 3 || b == 3 || c == 3);
    e = model(a, b, c);
    @(negedge clk);
    check(req, int'(f_out), e);
    check({req, " err flag R6"}, int'(code_err), int'(err));
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          apply(a, b, c, req);
  endtask

  task automatic set_term(int t, logic [2:0] ma, logic [2:0] mb, logic [2:0] mc, bit en, bit cap);
    mask_a[3*t +: 3] = ma; mask_b[3*t +: 3] = mb; mask_c[3*t +: 3] = mc;
    term_en[t] = en; term_cap[t] = cap;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // reference function (R8): a{0,1}b{0,1} + b{0,1}c{1,2} + 1.a{0} + 1.b{0,1}
    set_term(0, 3'b011, 3'b011, 3'b111, 1, 0);
    set_term(1, 3'b111, 3'b011, 3'b110, 1, 0);
    set_term(2, 3'b001, 3'b111, 3'b111, 1, 1);
    set_term(3, 3'b111, 3'b011, 3'b111, 1, 1);
    in_a = 2; in_b = 2; in_c = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset out", int'(f_out), 0);
    check("R7 reset err", int'(code_err), 0);
    rst_n = 1'b1;

    apply(1, 2, 0, "R8 (1,2,0)"); check("R8 anchor 0", int'(f_out), 0);
    apply(2, 0, 0, "R8 (2,0,0)"); check("R8 anchor 1", int'(f_out), 1);
    apply(0, 0, 0, "R8 (0,0,0)"); check("R8 anchor 2", int'(f_out), 2);
    sweep("R5 R8 reference sweep");

    // single literal per term, R2 mask positions
    set_term(0, 3'b100, 3'b111, 3'b111, 1, 0);
    set_term(1, 3'b111, 3'b010, 3'b111, 1, 1);
    set_term(2, 3'b111, 3'b111, 3'b001, 0, 0);
    set_term(3, 3'b101, 3'b101, 3'b010, 1, 0);
    sweep("R2 R3 R4 mixed sweep");

    // R9 full masks
    set_term(0, 3'b111, 3'b111, 3'b111, 1, 0);
    term_en[3:1] = '0;
    sweep("R9 full masks");
    apply(2, 1, 0, "R9 full"); check("R9 value 2", int'(f_out), 2);

    // capped full term gives 1 (R3)
    term_cap[0] = 1'b1;
    apply(0, 2, 1, "R3 cap"); check("R3 capped level", int'(f_out), 1);

    // R4 all disabled
    term_en = '0;
    sweep("R4 all off");

    // R6 illegal codes, with a function that would otherwise give 2
    term_en[0] = 1'b1; term_cap[0] = 1'b0;
    apply(3, 0, 0, "R6 bad a"); check("R6 forced zero", int'(f_out), 0);
    apply(0, 3, 0, "R6 bad b");
    apply(0, 0, 3, "R6 bad c");
    apply(1, 1, 1, "R6 recovery"); check("R1 R6 recovered", int'(f_out), 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule